// File: doc/BRIEF.md
# Shared Queue Status Bus Generator

This block condenses the per-queue flag state of a multi-queue buffer onto two narrow 8-bit status buses. One bus serves the write side and carries the almost-full flag of each queue. The other serves the read side and carries either the almost-empty flag or the packet-ready flag of each queue. Neither bus is limited to the queue that a port currently has selected, so an external controller can watch every queue without addressing each one in turn.

When eight queues or fewer are configured, the bus has one bit per queue and never changes group. With more queues, the bus shows one group of eight queues at a time. In polled mode the group advances on every clock and wraps after the last configured group. In direct mode a strobe loads a group address, and that group stays on the bus until the next strobe. The queue count, the mode of each bus and the read-side flag source are taken while reset is held. The bus and its group number are registered together, so they always describe the same group.

Top module: `fsb_top`

## Requirements
- R1: While rst_n is low at a clock edge, both buses and both group outputs are zero from that edge on.
- R2: When the latched queue count is 8 or less, each bus always shows group 0, so bit i carries queue i. This holds in both modes and for any strobe or address.
- R3: In polled mode with more than one configured group, the first edge after reset shows group 0, and each later edge shows the next group.
- R4: In polled mode the group after the last configured group is group 0. The last configured group is ceil(min(count, NUM_Q) / 8) - 1.
- R5: In direct mode, a strobe sampled at an edge puts its group address on the bus at that same edge. Without a strobe, the group output stays unchanged.
- R6: A bus bit whose queue index (group * 8 + bit) is at or above the latched count, or at or above NUM_Q, reads 0. This includes groups addressed beyond the configured ones.
- R7: Bus bit i shows the flag of queue group * 8 + i as sampled at the edge that loads the bus, which is one clock after the inputs are presented.
- R8: The write bus takes almost-full flags. The read bus takes packet-ready flags when cfg_rd_pkt was 1 during reset, and almost-empty flags when it was 0.
- R9: Queue count, modes and read flag source are latched only while rst_n is low. Changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_qcount | input | QCNT_W | Number of configured queues |
| cfg_wr_polled | input | 1 | Write bus mode: 1 polled, 0 direct |
| cfg_rd_polled | input | 1 | Read bus mode: 1 polled, 0 direct |
| cfg_rd_pkt | input | 1 | Read bus source: 1 packet-ready, 0 almost-empty |
| af_flags | input | NUM_Q | Per-queue almost-full flags |
| ae_flags | input | NUM_Q | Per-queue almost-empty flags |
| pr_flags | input | NUM_Q | Per-queue packet-ready flags |
| wr_strobe | input | 1 | Direct-mode group load for the write bus |
| wr_grp_addr | input | GRP_W | Group address for the write bus |
| rd_strobe | input | 1 | Direct-mode group load for the read bus |
| rd_grp_addr | input | GRP_W | Group address for the read bus |
| wr_bus | output | 8 | Write-side status bus |
| wr_grp | output | GRP_W | Group shown on wr_bus |
| rd_bus | output | 8 | Read-side status bus |
| rd_grp | output | GRP_W | Group shown on rd_bus |

## Verification
The bench sweeps queue counts of 0, 1, 5, 8, 9, 16, 17, 31, 32 and 40, driving fresh random flags on every cycle. It tracks each group number and the partial last group arithmetically.

- A wrap-point error shows as a polled bus that visits an unconfigured group or skips group 0.
- A missing tail mask shows as set bits above the queue count.
- A one-group configuration that still follows strobes or polling shows as a nonzero group.
- A direct mode that registers the address too late shows the old group for one cycle.
- A read source selected wrongly shows almost-empty data when packet-ready was chosen.
- One run alters every configuration input after reset. It catches a design that keeps sampling the configuration.

// File: rtl/fsb_pkg.sv
// Shared constants and types for the queue status bus generator.
// Assumes an 8-bit status bus; SEL_W is the bit-select width inside a group.
package fsb_pkg;
    localparam int unsigned STAT_W = 8;
    localparam int unsigned SEL_W  = $clog2(STAT_W);

    typedef enum logic {
        SEL_DIRECT = 1'b0,
        SEL_POLLED = 1'b1
    } grp_mode_e;
endpackage

// File: rtl/fsb_group_sel.sv
// Group selector: yields the group to be loaded onto the bus this cycle.
// Polled mode walks 0..last and wraps; direct mode follows a strobed address.
// Assumes mode and qcount are constant outside reset.
module fsb_group_sel
    import fsb_pkg::*;
#(
    parameter int unsigned NUM_Q  = 32,
    parameter int unsigned QCNT_W = 6,
    parameter int unsigned GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grp_mode_e         mode,
    input  logic [QCNT_W-1:0] qcount,
    input  logic              strobe,
    input  logic [GRP_W-1:0]  addr,
    output logic [GRP_W-1:0]  cur_grp
);
    localparam int unsigned NW = QCNT_W + 1;

    logic [QCNT_W-1:0] qc_eff;
    logic [NW-1:0]     ngrp;
    logic              single;
    logic [GRP_W-1:0]  last_grp;
    logic [GRP_W-1:0]  ptr_q;

    // Derive the number of configured groups and the wrap point.
    always_comb begin
        qc_eff   = (qcount > QCNT_W'(NUM_Q)) ? QCNT_W'(NUM_Q) : qcount;
        ngrp     = ({1'b0, qc_eff} + NW'(STAT_W - 1)) >> SEL_W;
        single   = (ngrp <= NW'(1));
        last_grp = single ? '0 : GRP_W'(ngrp - NW'(1));
    end

    // Choose the group presented this cycle.
    always_comb begin
        if (single)
            cur_grp = '0;
        else if (mode == SEL_POLLED)
            cur_grp = ptr_q;
        else
            cur_grp = strobe ? addr : ptr_q;
    end

    // Hold the pointer: advance when polled, remember the selection when direct.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (single)
            ptr_q <= '0;
        else if (mode == SEL_POLLED)
            ptr_q <= (cur_grp >= last_grp) ? '0 : cur_grp + GRP_W'(1);
        else
            ptr_q <= cur_grp;
    end

    // R3
    poll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_POLLED && !single && ptr_q < last_grp)
        |=> ptr_q == $past(ptr_q) + GRP_W'(1));

    // R4
    poll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_POLLED && !single && ptr_q >= last_grp)
        |=> ptr_q == '0);
endmodule

// File: rtl/fsb_group_mux.sv
// Group multiplexer: registers the eight flags of the chosen group and
// the group number, blanking bits whose queue index is not configured.
// Assumes qcount is constant outside reset.
module fsb_group_mux
    import fsb_pkg::*;
#(
    parameter int unsigned NUM_Q  = 32,
    parameter int unsigned QCNT_W = 6,
    parameter int unsigned GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  flags,
    input  logic [QCNT_W-1:0] qcount,
    input  logic [GRP_W-1:0]  grp,
    output logic [STAT_W-1:0] bus_q,
    output logic [GRP_W-1:0]  grp_q
);
    localparam int unsigned PAD_Q = (1 << GRP_W) * STAT_W;

    logic [PAD_Q-1:0]  flags_pad;
    logic [STAT_W-1:0] slice;
    logic [STAT_W-1:0] valid;

    assign flags_pad = PAD_Q'(flags);
    assign slice     = flags_pad[32'(grp) * STAT_W +: STAT_W];

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        // Mark the bit valid when its queue index is configured.
        always_comb begin
            valid[b] = (32'({grp, SEL_W'(b)}) < 32'(qcount)) &&
                       (32'({grp, SEL_W'(b)}) < NUM_Q);
        end

        // R6
        tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (32'({grp_q, SEL_W'(b)}) >= 32'(qcount)) |-> !bus_q[b]);
    end

    // Register the masked group flags together with the group number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            grp_q <= '0;
        end else begin
            bus_q <= slice & valid;
            grp_q <= grp;
        end
    end
endmodule

// File: rtl/fsb_lane.sv
// One status bus: a group selector feeding a registered group multiplexer.
// Assumes its configuration inputs are latched by the parent.
module fsb_lane
    import fsb_pkg::*;
#(
    parameter int unsigned NUM_Q  = 32,
    parameter int unsigned QCNT_W = 6,
    parameter int unsigned GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grp_mode_e         mode,
    input  logic [QCNT_W-1:0] qcount,
    input  logic [NUM_Q-1:0]  flags,
    input  logic              strobe,
    input  logic [GRP_W-1:0]  addr,
    output logic [STAT_W-1:0] bus,
    output logic [GRP_W-1:0]  grp
);
    logic [GRP_W-1:0] cur_grp;

    fsb_group_sel #(.NUM_Q(NUM_Q), .QCNT_W(QCNT_W), .GRP_W(GRP_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .mode(mode), .qcount(qcount),
        .strobe(strobe), .addr(addr), .cur_grp(cur_grp)
    );

    fsb_group_mux #(.NUM_Q(NUM_Q), .QCNT_W(QCNT_W), .GRP_W(GRP_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .flags(flags), .qcount(qcount),
        .grp(cur_grp), .bus_q(bus), .grp_q(grp)
    );

    // R5
    direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SEL_DIRECT && !strobe) |=> $stable(grp));

    // R2
    single_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(qcount) <= STAT_W) |-> grp == '0);
endmodule

// File: rtl/fsb_top.sv
// Top: latches configuration during reset and drives two status lanes,
// the write lane from almost-full flags and the read lane from either
// almost-empty or packet-ready flags.
// Assumes rst_n is held low for at least one clock edge.
module fsb_top
    import fsb_pkg::*;
#(
    parameter int unsigned NUM_Q  = 32,
    parameter int unsigned QCNT_W = $clog2(NUM_Q + 1),
    parameter int unsigned GRP_W  = (NUM_Q > 8) ? $clog2((NUM_Q + 7) / 8) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QCNT_W-1:0] cfg_qcount,
    input  logic              cfg_wr_polled,
    input  logic              cfg_rd_polled,
    input  logic              cfg_rd_pkt,
    input  logic [NUM_Q-1:0]  af_flags,
    input  logic [NUM_Q-1:0]  ae_flags,
    input  logic [NUM_Q-1:0]  pr_flags,
    input  logic              wr_strobe,
    input  logic [GRP_W-1:0]  wr_grp_addr,
    input  logic              rd_strobe,
    input  logic [GRP_W-1:0]  rd_grp_addr,
    output logic [7:0]        wr_bus,
    output logic [GRP_W-1:0]  wr_grp,
    output logic [7:0]        rd_bus,
    output logic [GRP_W-1:0]  rd_grp
);
    logic [QCNT_W-1:0] qc_q;
    grp_mode_e         wr_mode_q;
    grp_mode_e         rd_mode_q;
    logic              rd_pkt_q;
    logic [NUM_Q-1:0]  rd_src;

    // Capture the configuration only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qc_q      <= cfg_qcount;
            wr_mode_q <= grp_mode_e'(cfg_wr_polled);
            rd_mode_q <= grp_mode_e'(cfg_rd_polled);
            rd_pkt_q  <= cfg_rd_pkt;
        end
    end

    // Pick the flag source of the read lane.
    assign rd_src = rd_pkt_q ? pr_flags : ae_flags;

    fsb_lane #(.NUM_Q(NUM_Q), .QCNT_W(QCNT_W), .GRP_W(GRP_W)) u_wr_lane (
        .clk(clk), .rst_n(rst_n), .mode(wr_mode_q), .qcount(qc_q),
        .flags(af_flags), .strobe(wr_strobe), .addr(wr_grp_addr),
        .bus(wr_bus), .grp(wr_grp)
    );

    fsb_lane #(.NUM_Q(NUM_Q), .QCNT_W(QCNT_W), .GRP_W(GRP_W)) u_rd_lane (
        .clk(clk), .rst_n(rst_n), .mode(rd_mode_q), .qcount(qc_q),
        .flags(rd_src), .strobe(rd_strobe), .addr(rd_grp_addr),
        .bus(rd_bus), .grp(rd_grp)
    );

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(qc_q) && $stable(wr_mode_q) &&
                  $stable(rd_mode_q) && $stable(rd_pkt_q));
endmodule

// File: tb/fsb_top_test.sv
// Self-checking bench: sweeps queue counts and both modes on each lane.
module fsb_top_test;
    localparam int NQ = 32;
    localparam int QW = 6;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] cfg_qcount = '0;
    logic          cfg_wr_polled = 1'b0, cfg_rd_polled = 1'b0, cfg_rd_pkt = 1'b0;
    logic [NQ-1:0] af_flags = '0, ae_flags = '0, pr_flags = '0;
    logic          wr_strobe = 1'b0, rd_strobe = 1'b0;
    logic [GW-1:0] wr_grp_addr = '0, rd_grp_addr = '0;
    logic [7:0]    wr_bus, rd_bus;
    logic [GW-1:0] wr_grp, rd_grp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fsb_top #(.NUM_Q(NQ)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_qcount(cfg_qcount),
        .cfg_wr_polled(cfg_wr_polled), .cfg_rd_polled(cfg_rd_polled),
        .cfg_rd_pkt(cfg_rd_pkt), .af_flags(af_flags), .ae_flags(ae_flags),
        .pr_flags(pr_flags), .wr_strobe(wr_strobe), .wr_grp_addr(wr_grp_addr),
        .rd_strobe(rd_strobe), .rd_grp_addr(rd_grp_addr),
        .wr_bus(wr_bus), .wr_grp(wr_grp), .rd_bus(rd_bus), .rd_grp(rd_grp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int eff_q(input int qc);
        return (qc > NQ) ? NQ : qc;
    endfunction

    function automatic bit is_single(input int qc);
        return ((eff_q(qc) + 7) / 8) <= 1;
    endfunction

    function automatic int last_of(input int qc);
        return is_single(qc) ? 0 : ((eff_q(qc) + 7) / 8) - 1;
    endfunction

    function automatic logic [7:0] exp_bus(input logic [NQ-1:0] f, input int g, input int qc);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            int q = g * 8 + i;
            r[i] = (q < qc && q < NQ) ? f[q] : 1'b0;
        end
        return r;
    endfunction

    task automatic model(input bit poll, input bit stb, input int addr, input int qc,
                         inout int ptr, output int show);
        if (is_single(qc)) begin
            ptr = 0; show = 0;
        end else if (poll) begin
            show = ptr;
            ptr = (ptr >= last_of(qc)) ? 0 : ptr + 1;
        end else begin
            if (stb) ptr = addr;
            show = ptr;
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_cfg(input int qc, input bit wpoll, input bit rpoll,
                           input bit pkt, input bit scramble, input int cycles);
        int wptr = 0, rptr = 0, wshow, rshow;
        logic [NQ-1:0] af_c, rd_c;
        bit wstb, rstb;
        int waddr, raddr;
        string gt, bt;
        rst_n = 1'b0;
        cfg_qcount = QW'(qc);
        cfg_wr_polled = wpoll; cfg_rd_polled = rpoll; cfg_rd_pkt = pkt;
        wr_strobe = 1'b0; rd_strobe = 1'b0;
        af_flags = '1; ae_flags = '1; pr_flags = '1;
        step; step;
        // R1: reset state
        chk("R1 wr_bus", 32'(wr_bus), 0);
        chk("R1 rd_bus", 32'(rd_bus), 0);
        chk("R1 wr_grp", 32'(wr_grp), 0);
        chk("R1 rd_grp", 32'(rd_grp), 0);
        rst_n = 1'b1;
        if (scramble) begin
            cfg_qcount = ~QW'(qc);
            cfg_wr_polled = ~wpoll; cfg_rd_polled = ~rpoll; cfg_rd_pkt = ~pkt;
        end
        for (int c = 0; c < cycles; c++) begin
            af_flags = $urandom; ae_flags = $urandom; pr_flags = $urandom;
            wstb = ($urandom % 3) == 0; rstb = ($urandom % 3) == 0;
            waddr = $urandom % 4; raddr = $urandom % 4;
            wr_strobe = wstb; rd_strobe = rstb;
            wr_grp_addr = GW'(waddr); rd_grp_addr = GW'(raddr);
            af_c = af_flags;
            rd_c = pkt ? pr_flags : ae_flags;
            model(wpoll, wstb, waddr, qc, wptr, wshow);
            model(rpoll, rstb, raddr, qc, rptr, rshow);
            step;
            if (scramble) begin
                chk("R9 wr_grp", 32'(wr_grp), 32'(wshow));
                chk("R9 wr_bus", 32'(wr_bus), 32'(exp_bus(af_c, wshow, qc)));
                chk("R9 rd_grp", 32'(rd_grp), 32'(rshow));
                chk("R9 rd_bus", 32'(rd_bus), 32'(exp_bus(rd_c, rshow, qc)));
            end else begin
                gt = is_single(qc) ? "R2" : (wpoll ? ((wshow == 0 && c > 0) ? "R4" : "R3") : "R5");
                bt = (eff_q(qc) < (wshow + 1) * 8) ? "R6" : "R7";
                chk({gt, " wr_grp"}, 32'(wr_grp), 32'(wshow));
                chk({bt, " wr_bus"}, 32'(wr_bus), 32'(exp_bus(af_c, wshow, qc)));
                gt = is_single(qc) ? "R2" : (rpoll ? ((rshow == 0 && c > 0) ? "R4" : "R3") : "R5");
                bt = pkt ? "R8" : ((eff_q(qc) < (rshow + 1) * 8) ? "R6" : "R7");
                chk({gt, " rd_grp"}, 32'(rd_grp), 32'(rshow));
                chk({bt, " rd_bus"}, 32'(rd_bus), 32'(exp_bus(rd_c, rshow, qc)));
            end
        end
    endtask

    initial begin
        int qcs[10] = '{0, 1, 5, 8, 9, 16, 17, 31, 32, 40};
        @(negedge clk);
        foreach (qcs[k]) begin
            run_cfg(qcs[k], 1'b1, 1'b0, 1'b0, 1'b0, 40);
            run_cfg(qcs[k], 1'b0, 1'b1, 1'b1, 1'b0, 40);
        end
        run_cfg(20, 1'b1, 1'b0, 1'b1, 1'b1, 40);
        run_cfg(27, 1'b0, 1'b1, 1'b0, 1'b1, 40);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule